// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block forms the second operand of a 32-bit ALU together with the carry that the shifter hands to the flag logic. It takes a 12-bit operand field from the instruction, a flag that selects the immediate form, the value of the operand register, the low byte of the register that holds a shift amount, and the current carry flag. It is purely combinational. Both outputs follow the inputs in the same cycle and the block holds no state.

In the immediate form an 8-bit constant is rotated right by twice a 4-bit amount. In the register form the register value is shifted left or right with zero fill, shifted right with sign fill, rotated right, or rotated right by one bit through the carry flag. The shift amount comes either from a 5-bit field in the operand word or from the low byte of a second register. Register fetch and the ALU are outside the block. The caller decodes the register indices in the field and supplies the register values on their own ports.

A parameter selects how the shift network is built: a chain of log2 stages, or a single shift operator that is left to synthesis.

Top module: `barrel_operand2`

## Requirements
- R1: With `imm_sel`=1, `operand_out` equals the zero-extended `op_field[7:0]` rotated right by 2*`op_field[11:8]` (for example 0x4FF gives 0xFF000000 and 0xD40 gives 0x00001000).
- R2: With `imm_sel`=1, `carry_out` equals `c_in` when `op_field[11:8]` is 0. Otherwise it equals bit 31 of `operand_out`.
- R3: With `imm_sel`=0, `op_field[6:5]` selects the kind: 00 left shift with zero fill, 01 right shift with zero fill, 10 right shift with sign fill, 11 right rotate. `op_field[4]`=0 takes the amount from `op_field[11:7]`, and `op_field[4]`=1 takes it from `rs_low`. `op_field[3:0]` has no effect, and neither has `op_field[11:7]` when `op_field[4]`=1.
- R4: For an amount from 1 to 31, the register value is shifted or rotated as selected, and `carry_out` is the last bit moved out: bit 32-n for a left shift and bit n-1 for the right kinds.
- R5: An immediate left shift by 0, or any register-amount kind with `rs_low`=0, passes `rm_val` through unchanged with `carry_out`=`c_in`.
- R6: An immediate right shift (zero or sign fill) with a 0 amount field shifts by 32. Zero fill gives 0 and sign fill gives 32 copies of bit 31. In both cases `carry_out` is `rm_val[31]`.
- R7: An immediate rotate with a 0 amount field rotates right by one bit through the carry. `operand_out` is {`c_in`, `rm_val[31:1]`} and `carry_out` is `rm_val[0]`.
- R8: A register-amount left or right zero-fill shift by 32 or more gives 0. The carry is `rm_val[0]` (left) or `rm_val[31]` (right) when the amount is exactly 32, and 0 when it is above 32.
- R9: A register-amount sign-fill shift by 32 or more gives 32 copies of `rm_val[31]`, with `carry_out`=`rm_val[31]`.
- R10: A register-amount rotate uses the amount modulo 32. A nonzero multiple of 32 returns `rm_val` unchanged with `carry_out`=`rm_val[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_field | input | 12 | Operand field of the instruction word |
| imm_sel | input | 1 | 1 selects the rotated-constant form |
| rm_val | input | 32 | Value of the operand register |
| rs_low | input | 8 | Low byte of the amount register |
| c_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The assertions are evaluated combinationally. They assume that every input is a settled, known value whenever the outputs are examined, with no X bits on the operand field or the register values. The bench changes all inputs together on the falling clock edge and compares the outputs only after they have settled. Its mixed pattern biases `rs_low` toward 0, 32 and values above 32, so that the fixed-point rules are reached as often as the ordinary shifts.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
   typedef enum logic [2:0] {
      K_LSL = 3'd0,
      K_LSR = 3'd1,
      K_ASR = 3'd2,
      K_ROR = 3'd3,
      K_RRX = 3'd4
   } shift_kind_e;

   localparam int STYLE_LOG  = 0;
   localparam int STYLE_OPER = 1;
endpackage

// File: rtl/bsh_decode.sv
module bsh_decode
   import bsh_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CONST_W = 8,
   parameter int ROT_W   = 4,
   parameter int RS_W    = 8
) (
   input  logic [CONST_W+ROT_W-1:0] field,
   input  logic                     imm_sel,
   input  logic [RS_W-1:0]          rs_low,
   input  logic [DATA_W-1:0]        rm_val,
   output shift_kind_e              kind,
   output logic [RS_W-1:0]          amount,
   output logic [DATA_W-1:0]        src
);
   localparam int FIELD_W = CONST_W + ROT_W;
   localparam int AMT_W   = $clog2(DATA_W);
   localparam logic [RS_W-1:0] FULL = RS_W'(DATA_W);

   logic [AMT_W-1:0] imm_amt;
   logic [1:0]       typ;

   assign imm_amt = field[FIELD_W-1 -: AMT_W];
   assign typ     = field[6:5];

   always_comb begin
      kind   = K_ROR;
      amount = '0;
      src    = rm_val;
      if (imm_sel) begin
         kind   = K_ROR;
         amount = RS_W'({field[FIELD_W-1 -: ROT_W], 1'b0});
         src    = DATA_W'(field[CONST_W-1:0]);
      end else if (field[4]) begin
         kind   = shift_kind_e'({1'b0, typ});
         amount = rs_low;
      end else begin
         kind   = shift_kind_e'({1'b0, typ});
         amount = RS_W'(imm_amt);
         if (imm_amt == '0) begin
            case (typ)
               2'b01, 2'b10: amount = FULL;
               2'b11:        kind   = K_RRX;
               default:      amount = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/bsh_rshift.sv
module bsh_rshift
   import bsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int STYLE  = STYLE_LOG
) (
   input  logic [DATA_W-1:0]         din,
   input  logic [$clog2(DATA_W)-1:0] amt,
   input  logic                      fill,
   output logic [DATA_W-1:0]         dout,
   output logic                      last_out
);
   localparam int AMT_W = $clog2(DATA_W);

   logic [DATA_W:0] ext_out;

   generate
      if (STYLE == STYLE_LOG) begin : g_log
         logic [DATA_W:0] stage [0:AMT_W];
         assign stage[0] = {din, 1'b0};
         for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stage[k+1] = amt[k] ? {{SH{fill}}, stage[k][DATA_W:SH]} : stage[k];
         end
         assign ext_out = stage[AMT_W];
      end else begin : g_oper
         logic signed [DATA_W+1:0] wide;
         logic signed [DATA_W+1:0] moved;
         assign wide    = {fill, din, 1'b0};
         assign moved   = wide >>> amt;
         assign ext_out = moved[DATA_W:0];
      end
   endgenerate

   assign dout     = ext_out[DATA_W:1];
   assign last_out = ext_out[0];
endmodule

// File: rtl/bsh_rotr.sv
module bsh_rotr
   import bsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int STYLE  = STYLE_LOG
) (
   input  logic [DATA_W-1:0]         din,
   input  logic [$clog2(DATA_W)-1:0] amt,
   output logic [DATA_W-1:0]         dout
);
   localparam int AMT_W = $clog2(DATA_W);

   generate
      if (STYLE == STYLE_LOG) begin : g_log
         logic [DATA_W-1:0] stage [0:AMT_W];
         assign stage[0] = din;
         for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stage[k+1] = amt[k] ? {stage[k][SH-1:0], stage[k][DATA_W-1:SH]} : stage[k];
         end
         assign dout = stage[AMT_W];
      end else begin : g_oper
         logic [2*DATA_W-1:0] twice;
         assign twice = {din, din} >> amt;
         assign dout  = twice[DATA_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/bsh_core.sv
module bsh_core
   import bsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int RS_W   = 8,
   parameter int STYLE  = STYLE_LOG
) (
   input  shift_kind_e       kind,
   input  logic [RS_W-1:0]   amount,
   input  logic [DATA_W-1:0] src,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              carry
);
   localparam int AMT_W = $clog2(DATA_W);
   localparam int MSB   = DATA_W - 1;
   localparam logic [RS_W-1:0] FULL = RS_W'(DATA_W);

   logic [DATA_W-1:0] src_rev, sh_in, sh_out, sh_out_rev, rot_out;
   logic              sh_last, fill;
   logic [AMT_W-1:0]  n;
   logic              is_zero, is_big, is_exact;

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         src_rev[i]    = src[MSB-i];
         sh_out_rev[i] = sh_out[MSB-i];
      end
   end

   assign sh_in    = (kind == K_LSL) ? src_rev : src;
   assign fill     = (kind == K_ASR) & src[MSB];
   assign n        = amount[AMT_W-1:0];
   assign is_zero  = (amount == '0);
   assign is_big   = (amount >= FULL);
   assign is_exact = (amount == FULL);

   bsh_rshift #(.DATA_W(DATA_W), .STYLE(STYLE)) u_rshift (
      .din(sh_in), .amt(n), .fill(fill), .dout(sh_out), .last_out(sh_last)
   );

   bsh_rotr #(.DATA_W(DATA_W), .STYLE(STYLE)) u_rotr (
      .din(src), .amt(n), .dout(rot_out)
   );

   always_comb begin
      res   = src;
      carry = c_in;
      case (kind)
         K_LSL: begin
            if (is_zero) begin
               res = src; carry = c_in;
            end else if (is_big) begin
               res = '0; carry = is_exact & src[0];
            end else begin
               res = sh_out_rev; carry = sh_last;
            end
         end
         K_LSR: begin
            if (is_zero) begin
               res = src; carry = c_in;
            end else if (is_big) begin
               res = '0; carry = is_exact & src[MSB];
            end else begin
               res = sh_out; carry = sh_last;
            end
         end
         K_ASR: begin
            if (is_zero) begin
               res = src; carry = c_in;
            end else if (is_big) begin
               res = {DATA_W{src[MSB]}}; carry = src[MSB];
            end else begin
               res = sh_out; carry = sh_last;
            end
         end
         K_ROR: begin
            if (is_zero) begin
               res = src; carry = c_in;
            end else begin
               res = rot_out; carry = rot_out[MSB];
            end
         end
         K_RRX: begin
            res = {c_in, src[MSB:1]}; carry = src[0];
         end
         default: begin
            res = src; carry = c_in;
         end
      endcase
   end
endmodule

// File: rtl/barrel_operand2.sv
module barrel_operand2
   import bsh_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CONST_W = 8,
   parameter int ROT_W   = 4,
   parameter int RS_W    = 8,
   parameter int STYLE   = STYLE_LOG
) (
   input  logic [CONST_W+ROT_W-1:0] op_field,
   input  logic                     imm_sel,
   input  logic [DATA_W-1:0]        rm_val,
   input  logic [RS_W-1:0]          rs_low,
   input  logic                     c_in,
   output logic [DATA_W-1:0]        operand_out,
   output logic                     carry_out
);
   localparam int FIELD_W = CONST_W + ROT_W;
   localparam int AMT_W   = $clog2(DATA_W);

   generate
      if (DATA_W != (1 << AMT_W)) begin : g_bad_width
         $error("DATA_W must be a power of two");
      end
      if (FIELD_W != AMT_W + 7) begin : g_bad_field
         $error("operand field must hold amount, kind, select and index bits");
      end
      if ((2 * ((1 << ROT_W) - 1)) >= DATA_W) begin : g_bad_rot
         $error("doubled rotate must stay below DATA_W");
      end
      if (RS_W <= AMT_W) begin : g_bad_rs
         $error("RS_W must be able to express amounts of DATA_W and beyond");
      end
      if (STYLE != STYLE_LOG && STYLE != STYLE_OPER) begin : g_bad_style
         $error("unknown STYLE");
      end
   endgenerate

   shift_kind_e       kind;
   logic [RS_W-1:0]   amount;
   logic [DATA_W-1:0] src;

   bsh_decode #(.DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W), .RS_W(RS_W)) u_decode (
      .field(op_field), .imm_sel(imm_sel), .rs_low(rs_low), .rm_val(rm_val),
      .kind(kind), .amount(amount), .src(src)
   );

   bsh_core #(.DATA_W(DATA_W), .RS_W(RS_W), .STYLE(STYLE)) u_core (
      .kind(kind), .amount(amount), .src(src), .c_in(c_in),
      .res(operand_out), .carry(carry_out)
   );
endmodule

// File: rtl/bsh_checker.sv
module bsh_checker #(
   parameter int DATA_W  = 32,
   parameter int CONST_W = 8,
   parameter int ROT_W   = 4,
   parameter int RS_W    = 8
) (
   input logic [CONST_W+ROT_W-1:0] op_field,
   input logic                     imm_sel,
   input logic [DATA_W-1:0]        rm_val,
   input logic [RS_W-1:0]          rs_low,
   input logic                     c_in,
   input logic [DATA_W-1:0]        operand_out,
   input logic                     carry_out
);
   localparam int FIELD_W = CONST_W + ROT_W;
   localparam logic [RS_W-1:0] FULL = RS_W'(DATA_W);

   always_comb begin
      // R1
      if (imm_sel)
         imm_popcount_chk: assert ($countones(operand_out) == $countones(op_field[CONST_W-1:0]));
      // R2
      if (imm_sel && op_field[FIELD_W-1 -: ROT_W] == '0)
         imm_norot_chk: assert (operand_out == DATA_W'(op_field[CONST_W-1:0]) && carry_out == c_in);
      // R5
      if (!imm_sel && op_field[4] && rs_low == '0)
         reg_zero_pass_chk: assert (operand_out == rm_val && carry_out == c_in);
      // R7
      if (!imm_sel && !op_field[4] && op_field[6:5] == 2'b11 && op_field[11:7] == '0)
         rrx_chk: assert (operand_out[DATA_W-1] == c_in && carry_out == rm_val[0]);
      // R8
      if (!imm_sel && op_field[4] && !op_field[6] && rs_low > FULL)
         big_logic_chk: assert (operand_out == '0 && !carry_out);
      // R9
      if (!imm_sel && op_field[6:5] == 2'b10)
         asr_sign_chk: assert (operand_out[DATA_W-1] == rm_val[DATA_W-1]);
   end
endmodule

bind barrel_operand2 bsh_checker #(
   .DATA_W(DATA_W), .CONST_W(CONST_W), .ROT_W(ROT_W), .RS_W(RS_W)
) u_bsh_checker (
   .op_field(op_field), .imm_sel(imm_sel), .rm_val(rm_val), .rs_low(rs_low),
   .c_in(c_in), .operand_out(operand_out), .carry_out(carry_out)
);

// File: tb/test_barrel_operand2.sv
`timescale 1ns/1ps
module test_barrel_operand2;
   logic        clk = 1'b0;
   logic [11:0] op_field = '0;
   logic        imm_sel = 1'b0;
   logic [31:0] rm_val = '0;
   logic [7:0]  rs_low = '0;
   logic        c_in = 1'b0;
   logic [31:0] operand_out;
   logic        carry_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #10 clk = ~clk;

   barrel_operand2 i_barrel_operand2 (
      .op_field(op_field), .imm_sel(imm_sel), .rm_val(rm_val), .rs_low(rs_low),
      .c_in(c_in), .operand_out(operand_out), .carry_out(carry_out)
   );

   function automatic void model(input logic [11:0] f, input bit imm, input logic [31:0] rm,
                                 input logic [7:0] rs, input bit c,
                                 output logic [31:0] r, output bit co);
      int amt;
      logic [63:0] w;
      if (imm) begin
         int rot = 2 * int'(f[11:8]);
         logic [31:0] v = {24'h0, f[7:0]};
         if (rot == 0) begin r = v; co = c; end
         else begin r = (v >> rot) | (v << (32 - rot)); co = r[31]; end
         return;
      end
      if (!f[4]) begin
         amt = int'(f[11:7]);
         if (amt == 0) begin
            case (f[6:5])
               2'b00: begin r = rm; co = c; return; end
               2'b11: begin r = {c, rm[31:1]}; co = rm[0]; return; end
               default: amt = 32;
            endcase
         end
      end else amt = int'(rs);
      if (amt == 0) begin r = rm; co = c; return; end
      case (f[6:5])
         2'b00: begin
            if (amt > 32) begin r = 0; co = 0; end
            else begin w = {32'h0, rm} << amt; r = w[31:0]; co = w[32]; end
         end
         2'b01: begin
            if (amt > 32) begin r = 0; co = 0; end
            else begin w = {rm, 32'h0} >> amt; r = w[63:32]; co = w[31]; end
         end
         2'b10: begin
            if (amt >= 32) begin r = {32{rm[31]}}; co = rm[31]; end
            else begin w = 64'($signed({rm, 32'h0}) >>> amt); r = w[63:32]; co = w[31]; end
         end
         default: begin
            int m = amt % 32;
            if (m == 0) begin r = rm; co = rm[31]; end
            else begin r = (rm >> m) | (rm << (32 - m)); co = r[31]; end
         end
      endcase
   endfunction

   task automatic apply_check(input string tag, input logic [11:0] f, input bit imm,
                              input logic [31:0] rm, input logic [7:0] rs, input bit c);
      logic [31:0] er;
      bit ec;
      @(negedge clk);
      op_field = f; imm_sel = imm; rm_val = rm; rs_low = rs; c_in = c;
      @(posedge clk);
      #2;
      model(f, imm, rm, rs, c, er, ec);
      n_checks++;
      if (operand_out !== er || carry_out !== ec) begin
         n_fail++;
         $display("FAIL %s: field=%h imm=%0d rm=%h rs=%h c=%0d got %h/%0d expected %h/%0d",
                  tag, f, imm, rm, rs, c, operand_out, carry_out, er, ec);
      end
   endtask

   task automatic expect_fixed(input string tag, input logic [31:0] er, input bit ec);
      n_checks++;
      if (operand_out !== er || carry_out !== ec) begin
         n_fail++;
         $display("FAIL %s: got %h/%0d expected %h/%0d", tag, operand_out, carry_out, er, ec);
      end
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      // R1 R2: worked constants
      apply_check("R1", 12'h4FF, 1, 32'h0, 8'h0, 0);
      expect_fixed("R1 0x4FF", 32'hFF000000, 1'b1);
      apply_check("R1", 12'hD40, 1, 32'h0, 8'h0, 1);
      expect_fixed("R1 4096", 32'h00001000, 1'b0);
      apply_check("R2", 12'h0A5, 1, 32'hFFFFFFFF, 8'h0, 1);
      expect_fixed("R2 no rotate", 32'h000000A5, 1'b1);
      // R3: index bits and ignored amount bits
      apply_check("R3", 12'h10F, 0, 32'h80000001, 8'h0, 0);
      apply_check("R3", 12'hF93, 0, 32'h12345678, 8'h04, 0);
      expect_fixed("R3 rs amount", 32'h23456780, 1'b1);
      // R4
      apply_check("R4", 12'h080, 0, 32'h80000001, 8'h0, 0);
      apply_check("R4", 12'h0A0, 0, 32'h80000003, 8'h0, 0);
      apply_check("R4", 12'h0C0, 0, 32'h80000001, 8'h0, 0);
      apply_check("R4", 12'hFE0, 0, 32'h80000001, 8'h0, 0);
      apply_check("R4", 12'h070, 0, 32'hF0000000, 8'd31, 0);
      // R5
      apply_check("R5", 12'h000, 0, 32'hDEADBEEF, 8'h0, 1);
      expect_fixed("R5 lsl0", 32'hDEADBEEF, 1'b1);
      for (int t = 0; t < 4; t++)
         apply_check("R5", {5'h1F, t[1:0], 1'b1, 4'h2}, 0, 32'hC0FFEE01, 8'h0, t[0]);
      // R6
      apply_check("R6", 12'h020, 0, 32'h80000000, 8'h0, 0);
      expect_fixed("R6 lsr32", 32'h0, 1'b1);
      apply_check("R6", 12'h040, 0, 32'h80000000, 8'h0, 0);
      expect_fixed("R6 asr32", 32'hFFFFFFFF, 1'b1);
      // R7
      apply_check("R7", 12'h060, 0, 32'h00000003, 8'h0, 1);
      expect_fixed("R7 rrx", 32'h80000001, 1'b1);
      // R8
      apply_check("R8", 12'h010, 0, 32'h00000001, 8'd32, 0);
      expect_fixed("R8 lsl32", 32'h0, 1'b1);
      apply_check("R8", 12'h030, 0, 32'h80000000, 8'd32, 0);
      expect_fixed("R8 lsr32", 32'h0, 1'b1);
      apply_check("R8", 12'h030, 0, 32'hFFFFFFFF, 8'd33, 1);
      expect_fixed("R8 lsr33", 32'h0, 1'b0);
      // R9
      apply_check("R9", 12'h050, 0, 32'h80000000, 8'd200, 0);
      expect_fixed("R9 asr200", 32'hFFFFFFFF, 1'b1);
      // R10
      apply_check("R10", 12'h070, 0, 32'h40000001, 8'd64, 0);
      expect_fixed("R10 ror64", 32'h40000001, 1'b0);
      apply_check("R10", 12'h070, 0, 32'h00000002, 8'd33, 0);
      expect_fixed("R10 ror33", 32'h00000001, 1'b0);
      // mixed patterns
      for (int i = 0; i < 3000; i++) begin
         logic [11:0] f = 12'($urandom);
         bit imm = 1'($urandom);
         logic [7:0] rs;
         case ($urandom % 4)
            0: rs = 8'h0;
            1: rs = 8'd32;
            2: rs = 8'd32 + 8'($urandom % 224);
            default: rs = 8'($urandom % 32);
         endcase
         apply_check(imm ? "R1" : "R4", f, imm, 32'($urandom), rs, 1'($urandom));
      end
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule